// File: doc/BRIEF.md
# Dual-Channel Wiper and Data Register Executor

This block keeps the register state of two digitally controlled potentiometer channels. It carries out the instructions that a serial-bus front end has already decoded. Each channel owns a volatile 8-bit wiper code and four 8-bit data registers that stand in for nonvolatile storage. The front end delivers four kinds of event, each as a one-cycle strobe: bus START and STOP, the fields of an instruction byte (4-bit opcode, 2-bit register select, 2-bit pot select), a data byte, and increment/decrement steps. The front end never raises START or STOP in the same cycle as a command, data or step strobe.

Instructions act on the wiper codes and data registers as follows. Reads and wiper changes take effect straight away. Any write into a data register is only staged. It is committed after STOP, and during the commit a busy flag stays high for a parameterised number of cycles that models the programming time. While busy is high, every command, data byte and step is ignored. The write-protect input blocks or cancels staged data register writes, and it never blocks wiper changes. After each reset release, every wiper is reloaded from data register 0 of its channel. The two wiper codes are the outputs of the block.

Top module: `potx_exec`

## Requirements
- R1: While reset is held, `rd_data` is 0. For the first cycle after reset release, `busy` is 1. After that cycle, each `wiper[c]` equals data register 0 of channel c and `busy` is 0. Data register contents are kept across reset.
- R2: Opcode 4'b1001 (read wiper) loads `wiper[pot]` into `rd_data`. Opcode 4'b1011 (read data register) loads data register `reg` of channel `pot` into `rd_data`. Either value is visible one cycle after `cmd_valid`. Without a read command, `rd_data` holds its value.
- R3: Opcode 4'b1010 (write wiper) followed by `data_valid` sets `wiper[pot]` to `data_byte` one cycle after the data strobe. Write protect has no effect on this.
- R4: Opcode 4'b1100 (write data register) followed by a data byte stages the byte for register `reg` of channel `pot`. The staged value is committed only when `bus_stop` arrives. `busy` then rises one cycle after the STOP strobe and stays high for exactly WRITE_CYC cycles. The new value can be read once `busy` is low again.
- R5: Opcode 4'b1101 copies data register `reg` of channel `pot` into that wiper one cycle after `cmd_valid`. Opcode 4'b1110 stages the current wiper code for data register `reg` of channel `pot`, and that value is committed at STOP as in R4.
- R6: Gang opcodes need pot select 2'b00 and act on both channels with the same `reg`. Opcode 4'b0001 copies each channel's register `reg` into its wiper one cycle after the command. Opcode 4'b1000 stages both wiper codes for register `reg`, committed at STOP as in R4.
- R7: Write protect (`wp_n` low) behaves as follows:
  - A data byte or wiper-to-register transfer that arrives while `wp_n` is low is not staged.
  - If `wp_n` goes low at any time before the commit begins, the staged write is discarded, so no busy period follows.
  - If `wp_n` goes low after the busy period has begun, the write still completes.
- R8: A `bus_start` that arrives before STOP discards any staged data register write, so no busy period follows and the register keeps its old value.
- R9: While `busy` is high, commands, data bytes and steps are ignored. The wiper codes do not change.
- R10: Opcode 4'b0010 arms step mode for channel `pot`. Each `step_valid` then moves that wiper by +1 if `step_up` is 1, or by -1 if it is 0, one cycle later. The wiper saturates at 255 and 0. The other channel is unaffected. START or STOP ends step mode.
- R11: The following are ignored and change no wiper, data register or `rd_data`:
  - opcodes outside the nine listed;
  - single-channel opcodes with pot select 2 or 3;
  - gang opcodes with a non-zero pot select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write protect, low blocks data register programming |
| bus_start | input | 1 | One-cycle strobe for a bus START |
| bus_stop | input | 1 | One-cycle strobe for a bus STOP |
| cmd_valid | input | 1 | Instruction byte accepted strobe |
| cmd_op | input | 4 | Instruction opcode |
| cmd_reg | input | 2 | Data register select |
| cmd_pot | input | 2 | Channel select |
| data_valid | input | 1 | Data byte accepted strobe |
| data_byte | input | 8 | Data byte for write instructions |
| step_valid | input | 1 | One increment/decrement step |
| step_up | input | 1 | Step direction, 1 up, 0 down |
| busy | output | 1 | Recall or programming in progress |
| rd_data | output | 8 | Result of the last read instruction |
| wiper | output | 2x8 | Wiper code of each channel |

## Verification
Several results are due one cycle after the edge that accepts their strobe:
- read results;
- wiper writes;
- register-to-wiper transfers, single and gang;
- steps.

The bench drives every strobe for one cycle starting at a falling edge and samples at the next falling edge, so each check lands on the first cycle the result is due. For commits, `busy` is sampled at the falling edge right after the STOP strobe and then counted on each falling edge until it drops; the count must equal WRITE_CYC. The committed byte is read back only after `busy` has dropped. Cases that must have no effect are checked at the ports: the wiper outputs, or a register read-back after the point where a busy period would have ended.

// File: rtl/potx_pkg.sv
package potx_pkg;

  typedef enum logic [3:0] {
    OP_GANG_D2W = 4'b0001,
    OP_STEP     = 4'b0010,
    OP_GANG_W2D = 4'b1000,
    OP_RD_WIPER = 4'b1001,
    OP_WR_WIPER = 4'b1010,
    OP_RD_DREG  = 4'b1011,
    OP_WR_DREG  = 4'b1100,
    OP_D2W      = 4'b1101,
    OP_W2D      = 4'b1110
  } op_e;

  typedef struct packed {
    logic rd_wiper;
    logic rd_dreg;
    logic arm_wwr;
    logic arm_dwr;
    logic load_w;
    logic save_w;
    logic arm_step;
  } act_t;

endpackage

// File: rtl/potx_decode.sv
module potx_decode
  import potx_pkg::*;
#(
  parameter int CH = 2,
  parameter int PW = 2
) (
  input  logic [3:0]    op_i,
  input  logic [PW-1:0] pot_i,
  output act_t          act_o,
  output logic [CH-1:0] mask_o
);

  logic single_ok;
  logic gang_ok;

  always_comb begin
    single_ok = (int'(pot_i) < CH);
    gang_ok   = (pot_i == '0);
    act_o     = '0;
    mask_o    = '0;
    case (op_i)
      OP_RD_WIPER: if (single_ok) begin act_o.rd_wiper = 1'b1; mask_o = CH'(1) << pot_i; end
      OP_RD_DREG:  if (single_ok) begin act_o.rd_dreg  = 1'b1; mask_o = CH'(1) << pot_i; end
      OP_WR_WIPER: if (single_ok) begin act_o.arm_wwr  = 1'b1; mask_o = CH'(1) << pot_i; end
      OP_WR_DREG:  if (single_ok) begin act_o.arm_dwr  = 1'b1; mask_o = CH'(1) << pot_i; end
      OP_D2W:      if (single_ok) begin act_o.load_w   = 1'b1; mask_o = CH'(1) << pot_i; end
      OP_W2D:      if (single_ok) begin act_o.save_w   = 1'b1; mask_o = CH'(1) << pot_i; end
      OP_STEP:     if (single_ok) begin act_o.arm_step = 1'b1; mask_o = CH'(1) << pot_i; end
      OP_GANG_D2W: if (gang_ok)   begin act_o.load_w   = 1'b1; mask_o = '1; end
      OP_GANG_W2D: if (gang_ok)   begin act_o.save_w   = 1'b1; mask_o = '1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/potx_chan.sv
module potx_chan #(
  parameter int W   = 8,
  parameter int NDR = 4,
  localparam int RW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    recall_i,
  input  logic                    wwr_i,
  input  logic [W-1:0]            wwr_val_i,
  input  logic                    load_i,
  input  logic [RW-1:0]           load_idx_i,
  input  logic                    step_up_i,
  input  logic                    step_dn_i,
  input  logic                    dr_we_i,
  input  logic [RW-1:0]           dr_idx_i,
  input  logic [W-1:0]            dr_val_i,
  output logic [W-1:0]            wiper_o,
  output logic [NDR-1:0][W-1:0]   dr_o
);

  logic [W-1:0] wiper_q;
  logic [W-1:0] wiper_d;
  logic         wiper_en;

  always_comb begin
    wiper_d  = wiper_q;
    wiper_en = recall_i | wwr_i | load_i | step_up_i | step_dn_i;
    if (recall_i)                               wiper_d = dr_o[0];
    else if (wwr_i)                             wiper_d = wwr_val_i;
    else if (load_i)                            wiper_d = dr_o[load_idx_i];
    else if (step_up_i && (wiper_q != '1))      wiper_d = wiper_q + 1'b1;
    else if (step_dn_i && (wiper_q != '0))      wiper_d = wiper_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wiper_q <= '0;
    else if (wiper_en) wiper_q <= wiper_d;
  end

  assign wiper_o = wiper_q;

  for (genvar g = 0; g < NDR; g++) begin : g_cell
    logic [W-1:0] cell_q;
    logic         cell_we;
    assign cell_we = dr_we_i && (dr_idx_i == RW'(g));
    always_ff @(posedge clk) begin
      if (cell_we) cell_q <= dr_val_i;
    end
    assign dr_o[g] = cell_q;
  end

  AST_STEP_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up_i && !recall_i && !wwr_i && !load_i && (wiper_q == '1)) |=> (wiper_q == '1)); // R10
  AST_STEP_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn_i && !recall_i && !wwr_i && !load_i && (wiper_q == '0)) |=> (wiper_q == '0)); // R10

endmodule

// File: rtl/potx_nv.sv
module potx_nv #(
  parameter int CH        = 2,
  parameter int W         = 8,
  parameter int RW        = 2,
  parameter int WRITE_CYC = 500000,
  localparam int CW       = $clog2(WRITE_CYC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  wp_n_i,
  input  logic                  stage_i,
  input  logic [CH-1:0]         stage_mask_i,
  input  logic [RW-1:0]         stage_idx_i,
  input  logic [CH-1:0][W-1:0]  stage_val_i,
  output logic                  prog_o,
  output logic                  commit_o,
  output logic [CH-1:0]         commit_mask_o,
  output logic [RW-1:0]         commit_idx_o,
  output logic [CH-1:0][W-1:0]  commit_val_o
);

  logic [CH-1:0]        pend_q, pend_d;
  logic [RW-1:0]        idx_q, idx_d;
  logic [CH-1:0][W-1:0] val_q, val_d;
  logic                 prog_q, prog_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 done;

  always_comb begin
    pend_d = pend_q;
    idx_d  = idx_q;
    val_d  = val_q;
    prog_d = prog_q;
    cnt_d  = cnt_q;
    done   = prog_q && (cnt_q == '0);
    if (prog_q) begin
      if (done) begin
        prog_d = 1'b0;
        pend_d = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (!wp_n_i || start_i) begin
      pend_d = '0;
    end else if (stop_i) begin
      if (|pend_q) begin
        prog_d = 1'b1;
        cnt_d  = CW'(WRITE_CYC - 1);
      end
    end else if (stage_i) begin
      pend_d = stage_mask_i;
      idx_d  = stage_idx_i;
      val_d  = stage_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      idx_q  <= '0;
      val_q  <= '0;
      prog_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      idx_q  <= idx_d;
      val_q  <= val_d;
      prog_q <= prog_d;
      cnt_q  <= cnt_d;
    end
  end

  assign prog_o        = prog_q;
  assign commit_o      = done;
  assign commit_mask_o = pend_q;
  assign commit_idx_o  = idx_q;
  assign commit_val_o  = val_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q && (cnt_q != '0)) |=> (prog_q && (cnt_q == $past(cnt_q) - 1'b1))); // R4
  AST_PROG_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_q) |-> $past(stop_i && wp_n_i && !start_i)); // R4
  AST_WP_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n_i && !prog_q) |=> (!prog_q && (pend_q == '0))); // R7
  AST_PROG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q && (cnt_q != '0)) |=> prog_q); // R7

endmodule

// File: rtl/potx_exec.sv
module potx_exec
  import potx_pkg::*;
#(
  parameter int CH        = 2,
  parameter int W         = 8,
  parameter int NDR       = 4,
  parameter int PW        = 2,
  parameter int WRITE_CYC = 500000,
  localparam int RW       = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int CIW      = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wp_n,
  input  logic                 bus_start,
  input  logic                 bus_stop,
  input  logic                 cmd_valid,
  input  logic [3:0]           cmd_op,
  input  logic [RW-1:0]        cmd_reg,
  input  logic [PW-1:0]        cmd_pot,
  input  logic                 data_valid,
  input  logic [W-1:0]         data_byte,
  input  logic                 step_valid,
  input  logic                 step_up,
  output logic                 busy,
  output logic [W-1:0]         rd_data,
  output logic [CH-1:0][W-1:0] wiper
);

  act_t                      dec_act;
  logic [CH-1:0]             dec_mask;
  logic [CIW-1:0]            pot_idx;

  logic                      recall_q;
  logic                      prog;
  logic                      accept;
  logic                      cmd_go, data_go, step_go, edge_ev;

  logic                      arm_wwr_q, arm_wwr_d;
  logic                      arm_dwr_q, arm_dwr_d;
  logic                      arm_step_q, arm_step_d;
  logic [CH-1:0]             arm_mask_q, arm_mask_d;
  logic [RW-1:0]             arm_idx_q, arm_idx_d;

  logic [W-1:0]              rd_q, rd_d;
  logic                      rd_en;

  logic                      stage;
  logic [CH-1:0]             stage_mask;
  logic [RW-1:0]             stage_idx;
  logic [CH-1:0][W-1:0]      stage_val;

  logic                      commit;
  logic [CH-1:0]             commit_mask;
  logic [RW-1:0]             commit_idx;
  logic [CH-1:0][W-1:0]      commit_val;

  logic [CH-1:0][W-1:0]      wip;
  logic [CH-1:0][NDR-1:0][W-1:0] drs;

  potx_decode #(.CH(CH), .PW(PW)) u_dec (
    .op_i   (cmd_op),
    .pot_i  (cmd_pot),
    .act_o  (dec_act),
    .mask_o (dec_mask)
  );

  assign pot_idx = cmd_pot[CIW-1:0];
  assign accept  = !recall_q && !prog;
  assign edge_ev = bus_start || bus_stop;
  assign cmd_go  = cmd_valid && accept && !edge_ev;
  assign data_go = data_valid && accept && !edge_ev;
  assign step_go = step_valid && accept && !edge_ev && arm_step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recall_q <= 1'b1;
    else        recall_q <= 1'b0;
  end

  always_comb begin
    arm_wwr_d  = arm_wwr_q;
    arm_dwr_d  = arm_dwr_q;
    arm_step_d = arm_step_q;
    arm_mask_d = arm_mask_q;
    arm_idx_d  = arm_idx_q;
    if (edge_ev) begin
      arm_wwr_d  = 1'b0;
      arm_dwr_d  = 1'b0;
      arm_step_d = 1'b0;
    end else if (cmd_go) begin
      arm_wwr_d  = dec_act.arm_wwr;
      arm_dwr_d  = dec_act.arm_dwr;
      arm_step_d = dec_act.arm_step;
      arm_mask_d = dec_mask;
      arm_idx_d  = cmd_reg;
    end else if (data_go) begin
      arm_wwr_d  = 1'b0;
      arm_dwr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_wwr_q  <= 1'b0;
      arm_dwr_q  <= 1'b0;
      arm_step_q <= 1'b0;
      arm_mask_q <= '0;
      arm_idx_q  <= '0;
    end else begin
      arm_wwr_q  <= arm_wwr_d;
      arm_dwr_q  <= arm_dwr_d;
      arm_step_q <= arm_step_d;
      arm_mask_q <= arm_mask_d;
      arm_idx_q  <= arm_idx_d;
    end
  end

  always_comb begin
    rd_en = cmd_go && (dec_act.rd_wiper || dec_act.rd_dreg);
    rd_d  = rd_q;
    if (dec_act.rd_wiper)     rd_d = wip[pot_idx];
    else if (dec_act.rd_dreg) rd_d = drs[pot_idx][cmd_reg];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  always_comb begin
    stage      = (cmd_go && dec_act.save_w) || (data_go && arm_dwr_q);
    stage_mask = cmd_go ? dec_mask : arm_mask_q;
    stage_idx  = cmd_go ? cmd_reg : arm_idx_q;
    for (int c = 0; c < CH; c++) begin
      stage_val[c] = cmd_go ? wip[c] : data_byte;
    end
  end

  potx_nv #(.CH(CH), .W(W), .RW(RW), .WRITE_CYC(WRITE_CYC)) u_nv (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (bus_start),
    .stop_i        (bus_stop),
    .wp_n_i        (wp_n),
    .stage_i       (stage),
    .stage_mask_i  (stage_mask),
    .stage_idx_i   (stage_idx),
    .stage_val_i   (stage_val),
    .prog_o        (prog),
    .commit_o      (commit),
    .commit_mask_o (commit_mask),
    .commit_idx_o  (commit_idx),
    .commit_val_o  (commit_val)
  );

  for (genvar c = 0; c < CH; c++) begin : g_ch
    potx_chan #(.W(W), .NDR(NDR)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .recall_i   (recall_q),
      .wwr_i      (data_go && arm_wwr_q && arm_mask_q[c]),
      .wwr_val_i  (data_byte),
      .load_i     (cmd_go && dec_act.load_w && dec_mask[c]),
      .load_idx_i (cmd_reg),
      .step_up_i  (step_go && step_up && arm_mask_q[c]),
      .step_dn_i  (step_go && !step_up && arm_mask_q[c]),
      .dr_we_i    (commit && commit_mask[c]),
      .dr_idx_i   (commit_idx),
      .dr_val_i   (commit_val[c]),
      .wiper_o    (wip[c]),
      .dr_o       (drs[c])
    );

    AST_RECALL_DR0: assert property (@(posedge clk) disable iff (!rst_n)
      recall_q |=> (wip[c] == $past(drs[c][0]))); // R1
  end

  assign busy    = recall_q || prog;
  assign rd_data = rd_q;
  assign wiper   = wip;

  AST_PROG_FREEZES_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> $stable(wip)); // R9
  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(rd_q)); // R2

endmodule

// File: tb/sim_potx_exec.sv
module sim_potx_exec;

  localparam int WC = 12;

  logic clk = 1'b0;
  logic rst_n, wp_n, bus_start, bus_stop, cmd_valid, data_valid, step_valid, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [7:0] data_byte;
  logic busy;
  logic [7:0] rd_data;
  logic [1:0][7:0] wiper;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] got;
  logic [7:0] hold0, hold1;

  always #2.5 clk = ~clk;

  potx_exec #(.WRITE_CYC(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_pot(cmd_pot),
    .data_valid(data_valid), .data_byte(data_byte), .step_valid(step_valid), .step_up(step_up),
    .busy(busy), .rd_data(rd_data), .wiper(wiper)
  );

  // pot, value, expected wiper0, expected wiper1
  localparam logic [25:0] VEC [8] = '{
    {2'd0, 8'h3C, 8'h3C, 8'h00},
    {2'd1, 8'hA5, 8'h3C, 8'hA5},
    {2'd0, 8'hFF, 8'hFF, 8'hA5},
    {2'd1, 8'h00, 8'hFF, 8'h00},
    {2'd2, 8'h77, 8'hFF, 8'h00},
    {2'd3, 8'h12, 8'hFF, 8'h00},
    {2'd1, 8'h81, 8'hFF, 8'h81},
    {2'd0, 8'h01, 8'h01, 8'h81}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_start();
    @(negedge clk); bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask
  task automatic t_stop();
    @(negedge clk); bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask
  task automatic t_cmd(input logic [3:0] op, input logic [1:0] rg, input logic [1:0] pot);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_reg = rg; cmd_pot = pot;
    @(negedge clk); cmd_valid = 1'b0;
  endtask
  task automatic t_data(input logic [7:0] b);
    @(negedge clk); data_valid = 1'b1; data_byte = b; @(negedge clk); data_valid = 1'b0;
  endtask
  task automatic t_step(input logic up);
    @(negedge clk); step_valid = 1'b1; step_up = up; @(negedge clk); step_valid = 1'b0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask
  task automatic wr_wiper(input logic [1:0] pot, input logic [7:0] v);
    t_start(); t_cmd(4'b1010, 2'd0, pot); t_data(v); t_stop();
  endtask
  task automatic wr_dreg(input logic [1:0] pot, input logic [1:0] rg, input logic [7:0] v);
    t_start(); t_cmd(4'b1100, rg, pot); t_data(v); t_stop(); wait_idle();
  endtask
  task automatic rd_dreg(input logic [1:0] pot, input logic [1:0] rg, output logic [7:0] v);
    t_start(); t_cmd(4'b1011, rg, pot); v = rd_data; t_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wp_n = 1'b1; bus_start = 1'b0; bus_stop = 1'b0; cmd_valid = 1'b0;
    data_valid = 1'b0; step_valid = 1'b0; step_up = 1'b0;
    cmd_op = '0; cmd_reg = '0; cmd_pot = '0; data_byte = '0;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", {8'h0, rd_data}, 16'h0);
    rst_n = 1'b1;
    chk("R1 busy during recall", {15'h0, busy}, 16'h1);
    @(negedge clk);
    chk("R1 busy after recall", {15'h0, busy}, 16'h0);
    rd_dreg(2'd0, 2'd0, got);
    chk("R1 wiper0 equals DR0", {8'h0, wiper[0]}, {8'h0, got});
    rd_dreg(2'd1, 2'd0, got);
    chk("R1 wiper1 equals DR0", {8'h0, wiper[1]}, {8'h0, got});

    // R3 table of wiper writes, R2 read-back, R11 bad pot select
    wr_wiper(2'd0, 8'h00); wr_wiper(2'd1, 8'h00);
    for (int i = 0; i < 8; i++) begin
      wr_wiper(VEC[i][25:24], VEC[i][23:16]);
      chk($sformatf("R3 R11 vec%0d wiper0", i), {8'h0, wiper[0]}, {8'h0, VEC[i][15:8]});
      chk($sformatf("R3 R11 vec%0d wiper1", i), {8'h0, wiper[1]}, {8'h0, VEC[i][7:0]});
      if (VEC[i][25:24] < 2) begin
        t_start(); t_cmd(4'b1001, 2'd0, VEC[i][25:24]);
        chk($sformatf("R2 vec%0d read wiper", i), {8'h0, rd_data}, {8'h0, VEC[i][23:16]});
        t_stop();
      end
    end

    // R4 commit at STOP, busy length
    t_start(); t_cmd(4'b1100, 2'd2, 2'd0); t_data(8'h5A);
    chk("R4 no busy before STOP", {15'h0, busy}, 16'h0);
    t_stop();
    begin
      int n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk("R4 busy length", 16'(n), 16'(WC));
    end
    rd_dreg(2'd0, 2'd2, got);
    chk("R4 DR2 ch0 committed", {8'h0, got}, 16'h005A);

    // R9 commands ignored while busy
    t_start(); t_cmd(4'b1100, 2'd1, 2'd0); t_data(8'h21); t_stop();
    t_start(); t_cmd(4'b1010, 2'd0, 2'd0); t_data(8'h99); t_stop();
    chk("R9 wiper0 frozen while busy", {8'h0, wiper[0]}, 16'h0001);
    wait_idle();

    // R5 transfers
    t_start(); t_cmd(4'b1101, 2'd2, 2'd0);
    chk("R5 DR2 to wiper0", {8'h0, wiper[0]}, 16'h005A);
    t_stop();
    wr_wiper(2'd1, 8'hC3);
    t_start(); t_cmd(4'b1110, 2'd3, 2'd1); t_stop(); wait_idle();
    rd_dreg(2'd1, 2'd3, got);
    chk("R5 wiper1 to DR3", {8'h0, got}, 16'h00C3);

    // R6 gang transfers
    wr_dreg(2'd1, 2'd1, 8'h42);
    wr_wiper(2'd0, 8'h00); wr_wiper(2'd1, 8'h00);
    t_start(); t_cmd(4'b0001, 2'd1, 2'd0);
    chk("R6 gang DR1 to wiper0", {8'h0, wiper[0]}, 16'h0021);
    chk("R6 gang DR1 to wiper1", {8'h0, wiper[1]}, 16'h0042);
    t_stop();
    wr_wiper(2'd0, 8'h66); wr_wiper(2'd1, 8'h99);
    t_start(); t_cmd(4'b1000, 2'd0, 2'd0); t_stop(); wait_idle();
    rd_dreg(2'd0, 2'd0, got);
    chk("R6 gang wiper0 to DR0", {8'h0, got}, 16'h0066);
    rd_dreg(2'd1, 2'd0, got);
    chk("R6 gang wiper1 to DR0", {8'h0, got}, 16'h0099);
    t_start(); t_cmd(4'b0001, 2'd2, 2'd1);
    chk("R11 gang with pot 1 ignored", {wiper[0], wiper[1]}, 16'h6699);
    t_stop();

    // R7 write protect
    wp_n = 1'b0;
    t_start(); t_cmd(4'b1100, 2'd0, 2'd0); t_data(8'h10); t_stop();
    chk("R7 no busy under protect", {15'h0, busy}, 16'h0);
    wr_wiper(2'd0, 8'h44);
    chk("R7 wiper write under protect", {8'h0, wiper[0]}, 16'h0044);
    wp_n = 1'b1;
    rd_dreg(2'd0, 2'd0, got);
    chk("R7 DR0 kept under protect", {8'h0, got}, 16'h0066);
    t_start(); t_cmd(4'b1100, 2'd0, 2'd0); t_data(8'h20);
    @(negedge clk); wp_n = 1'b0; @(negedge clk); wp_n = 1'b1;
    t_stop();
    chk("R7 protect pulse cancels", {15'h0, busy}, 16'h0);
    rd_dreg(2'd0, 2'd0, got);
    chk("R7 DR0 kept after cancel", {8'h0, got}, 16'h0066);
    t_start(); t_cmd(4'b1100, 2'd0, 2'd0); t_data(8'h30); t_stop();
    wp_n = 1'b0;
    wait_idle();
    wp_n = 1'b1;
    rd_dreg(2'd0, 2'd0, got);
    chk("R7 protect during program no effect", {8'h0, got}, 16'h0030);

    // R8 new START discards pending
    t_start(); t_cmd(4'b1100, 2'd0, 2'd1); t_data(8'h55); t_start(); t_stop();
    chk("R8 no busy after restart", {15'h0, busy}, 16'h0);
    rd_dreg(2'd1, 2'd0, got);
    chk("R8 DR0 ch1 kept", {8'h0, got}, 16'h0099);

    // R10 step mode
    wr_wiper(2'd0, 8'hFE);
    hold1 = wiper[1];
    t_start(); t_cmd(4'b0010, 2'd0, 2'd0);
    t_step(1'b1);
    chk("R10 step up", {8'h0, wiper[0]}, 16'h00FF);
    t_step(1'b1);
    chk("R10 saturate at 255", {8'h0, wiper[0]}, 16'h00FF);
    t_step(1'b0); t_step(1'b0); t_step(1'b0);
    chk("R10 three steps down", {8'h0, wiper[0]}, 16'h00FC);
    chk("R10 other channel untouched", {8'h0, wiper[1]}, {8'h0, hold1});
    t_stop();
    t_step(1'b1);
    chk("R10 step after STOP ignored", {8'h0, wiper[0]}, 16'h00FC);
    wr_wiper(2'd1, 8'h01);
    t_start(); t_cmd(4'b0010, 2'd0, 2'd1);
    t_step(1'b0); t_step(1'b0);
    chk("R10 saturate at 0", {8'h0, wiper[1]}, 16'h0000);
    t_stop();

    // R11 unlisted opcodes and bad reads
    hold0 = wiper[0]; hold1 = wiper[1];
    t_start(); t_cmd(4'b1001, 2'd0, 2'd0); got = rd_data; t_stop();
    t_start(); t_cmd(4'b0000, 2'd0, 2'd0); t_data(8'hEE); t_stop();
    t_start(); t_cmd(4'b1111, 2'd1, 2'd1); t_data(8'hEE); t_stop();
    t_start(); t_cmd(4'b0011, 2'd0, 2'd0); t_step(1'b1); t_stop();
    chk("R11 unlisted opcodes no busy", {15'h0, busy}, 16'h0);
    chk("R11 unlisted opcodes wipers", {wiper[0], wiper[1]}, {hold0, hold1});
    t_start(); t_cmd(4'b1011, 2'd0, 2'd2);
    chk("R11 read with pot 2 ignored", {8'h0, rd_data}, {8'h0, got});
    t_stop();

    // R1 recall on a second reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 recall wiper0 from DR0", {8'h0, wiper[0]}, 16'h0030);
    chk("R1 recall wiper1 from DR0", {8'h0, wiper[1]}, 16'h0099);
    rd_dreg(2'd0, 2'd2, got);
    chk("R1 DR2 kept across reset", {8'h0, got}, 16'h005A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule